// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block connects a 16-bit core to a byte-addressed memory bus that is two bytes wide. The core hands it one request at a time: a read or a write, of one byte or one 16-bit word, at any 20-bit byte address. The sequencer works out which half of the bus each byte belongs on and drives the bus address, the two active-high lane enables and the write data. It holds each bus cycle until the memory raises its ready input. When the access is over it pulses `done` for one clock, and for a read it presents the result on `rdata`.

Words are little-endian: the low byte sits at the lower address. A word at an even address fits both lanes at once and takes one bus cycle. A word at an odd address straddles two bus words. The sequencer splits it into two byte cycles. The first carries the low byte on the upper lane at the given address. The second carries the high byte on the lower lane at the next address, and that address wraps from the top of the 1 MiB space to zero. The core sees the split access as a single operation with a single `done`. A request that arrives while an access is in progress is dropped, so the core waits for `done` before it issues the next one.

Top module: `bytelane_seq`

## Requirements
- R1: After reset, `bus_cyc`, `done` and both lane enables are low.
- R2: A byte access at an even address is one bus cycle at that address with `bus_be` = 01 (bit 0 marks lanes 7..0), and write data in `bus_wdata[7:0]`.
- R3: A byte access at an odd address is one bus cycle at that address with `bus_be` = 10 (bit 1 marks lanes 15..8), and write data in `bus_wdata[15:8]`.
- R4: A word access at an even address is one bus cycle with `bus_be` = 11, write data as given, and read data returned unchanged.
- R5: A word access at odd address A is two bus cycles. The first is at A with `bus_be` = 10 and carries the word's low byte in bits 15..8. The second follows directly, at A+1 with `bus_be` = 01, and carries the high byte in bits 7..0.
- R6: While `bus_cyc` is high and `bus_ready` is low, the address, the enables, the write flag and the write data stay unchanged.
- R7: `done` is high for exactly one clock, in the cycle after the final ready of an access. A split access gives only one `done`, and its read result is {second-cycle byte from lanes 7..0, first-cycle byte from lanes 15..8}.
- R8: The second cycle of a split word at address 0xFFFFF goes to address 0x00000.
- R9: A request raised while an access is in progress has no effect: the current cycle is unchanged and no further bus cycle follows.
- R10: A byte read returns the byte from its lane, selected by address parity, in `rdata[7:0]`, with `rdata[15:8]` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | The core offers a request; it is taken only when the sequencer is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7..0 |
| done | output | 1 | One-clock pulse when the access completes |
| rdata | output | 16 | Read result, valid while `done` is high for a read |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_wr | output | 1 | The current bus cycle is a write |
| bus_addr | output | 20 | Byte address of the current bus cycle |
| bus_be | output | 2 | Lane enables: bit 0 = lanes 7..0, bit 1 = lanes 15..8 |
| bus_wdata | output | 16 | Write data, steered to the enabled lanes |
| bus_ready | input | 1 | Memory ends the current bus cycle |
| bus_rdata | input | 16 | Read data from memory |

## Verification
A request taken at a rising edge shows its first bus cycle after that edge. Each ready sampled at an edge either starts the second cycle of a split word after that same edge or raises `done` and `rdata` after it, so a result is due one edge after the ready that finishes the access. The bench changes inputs and samples outputs only on falling edges, and every task steps through the edges one at a time. Each check therefore reads the cycle in which the design is meant to show its result. While ready is held low, the bench re-checks the bus fields at every falling edge. It also checks that `done` is low after the first half of a split word and low again one cycle after its pulse.

// File: rtl/bls_pkg.sv
package bls_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } bls_state_e;

   typedef struct packed {
      logic wr;
      logic word;
   } bls_kind_t;

endpackage

// File: rtl/bls_wr_steer.sv
module bls_wr_steer #(
   parameter int LANE_W = 8,
   localparam int DATA_W = 2 * LANE_W
) (
   input  logic              active,
   input  logic              second,
   input  logic              word,
   input  logic              odd,
   input  logic              is_write,
   input  logic [DATA_W-1:0] src,
   output logic [1:0]        be,
   output logic [DATA_W-1:0] lane_data
);

   logic full_word;
   logic take_hi;

   assign full_word = word & ~odd & ~second;
   assign take_hi   = second;

   always_comb begin
      if (!active)        be = 2'b00;
      else if (second)    be = 2'b01;
      else if (full_word) be = 2'b11;
      else if (odd)       be = 2'b10;
      else                be = 2'b01;
   end

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [LANE_W-1:0] pick;
      assign pick = full_word ? src[g*LANE_W +: LANE_W]
                  : (take_hi ? src[LANE_W +: LANE_W] : src[0 +: LANE_W]);
      assign lane_data[g*LANE_W +: LANE_W] =
         (be[g] && is_write) ? pick : '0;
   end

endmodule

// File: rtl/bls_rd_merge.sv
module bls_rd_merge #(
   parameter int LANE_W = 8,
   localparam int DATA_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grab_lo,
   input  logic              finish,
   input  logic              is_read,
   input  logic              word,
   input  logic              odd,
   input  logic              second,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] rdata
);

   logic [LANE_W-1:0] lo_q;
   logic [DATA_W-1:0] merged;

   always_comb begin
      if (second)
         merged = {bus_rdata[0 +: LANE_W], lo_q};
      else if (word)
         merged = bus_rdata;
      else if (odd)
         merged = {{LANE_W{1'b0}}, bus_rdata[LANE_W +: LANE_W]};
      else
         merged = {{LANE_W{1'b0}}, bus_rdata[0 +: LANE_W]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         rdata <= '0;
      end else begin
         if (grab_lo)
            lo_q <= bus_rdata[LANE_W +: LANE_W];
         if (finish && is_read)
            rdata <= merged;
      end
   end

endmodule

// File: rtl/bytelane_seq.sv
module bytelane_seq
   import bls_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8,
   localparam int DATA_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_cyc,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ready,
   input  logic [DATA_W-1:0] bus_rdata
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("bytelane_seq: ADDR_W must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("bytelane_seq: LANE_W must be positive");
   end

   bls_state_e        state_q, state_d;
   bls_kind_t         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q;

   logic accept, odd, split, second, grab_lo, finish;

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign odd     = addr_q[0];
   assign split   = kind_q.word & odd;
   assign second  = (state_q == ST_SECOND);
   assign grab_lo = (state_q == ST_FIRST) && bus_ready && split;
   assign finish  = bus_ready &&
                    (((state_q == ST_FIRST) && !split) || second);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (accept)  state_d = ST_FIRST;
         ST_FIRST:  if (grab_lo) state_d = ST_SECOND;
                    else if (finish) state_d = ST_IDLE;
         ST_SECOND: if (finish)  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept) begin
            kind_q.wr   <= req_write;
            kind_q.word <= req_word;
            addr_q      <= req_addr;
            wdata_q     <= req_wdata;
         end
      end
   end

   assign bus_cyc  = (state_q != ST_IDLE);
   assign bus_wr   = bus_cyc & kind_q.wr;
   assign bus_addr = second ? addr_q + ADDR_W'(1) : addr_q;
   assign done     = done_q;

   bls_wr_steer #(.LANE_W(LANE_W)) u_steer (
      .active    (bus_cyc),
      .second    (second),
      .word      (kind_q.word),
      .odd       (odd),
      .is_write  (kind_q.wr),
      .src       (wdata_q),
      .be        (bus_be),
      .lane_data (bus_wdata)
   );

   bls_rd_merge #(.LANE_W(LANE_W)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .grab_lo   (grab_lo),
      .finish    (finish),
      .is_read   (~kind_q.wr),
      .word      (kind_q.word),
      .odd       (odd),
      .second    (second),
      .bus_rdata (bus_rdata),
      .rdata     (rdata)
   );

endmodule

// File: rtl/bls_seq_chk.sv
module bls_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              bus_cyc,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_be,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ready
);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_wr) && $stable(bus_wdata)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_cyc && bus_ready));

   assert_lane_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> (bus_be != 2'b00));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc |-> (bus_be == 2'b00 && !bus_wr));

   assert_split_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_cyc && bus_ready) && bus_cyc) |->
         (bus_be == 2'b01 && $past(bus_be) == 2'b10
          && bus_addr == $past(bus_addr) + ADDR_W'(1)));

endmodule

bind bytelane_seq bls_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done),
   .bus_cyc   (bus_cyc),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready)
);

// File: tb/bytelane_seq_tb.sv
module bytelane_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rdata;
   logic        bus_cyc;
   logic        bus_wr;
   logic [19:0] bus_addr;
   logic [1:0]  bus_be;
   logic [15:0] bus_wdata;
   logic        bus_ready = 1'b0;
   logic [15:0] bus_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   bytelane_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata)
   );

   initial forever #5ns clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input bit w, input bit wd, input logic [19:0] a, input logic [15:0] d);
      req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic beat(input string tag, input logic [19:0] ea, input logic [1:0] ebe,
                       input bit ewr, input logic [15:0] ewd, input int waits,
                       input logic [15:0] rd);
      for (int i = 0; i <= waits; i++) begin
         string t;
         t = (i > 0) ? {tag, " R6 hold"} : tag;
         check({t, " cyc"},  32'(bus_cyc), 32'd1);
         check({t, " addr"}, 32'(bus_addr), 32'(ea));
         check({t, " be"},   32'(bus_be), 32'(ebe));
         check({t, " wr"},   32'(bus_wr), 32'(ewr));
         if (ewr) check({t, " wdata"}, 32'(bus_wdata), 32'(ewd));
         if (i < waits) begin
            bus_ready = 1'b0;
            @(negedge clk);
         end
      end
      bus_ready = 1'b1; bus_rdata = rd;
      @(negedge clk);
      bus_ready = 1'b0; bus_rdata = '0;
   endtask

   task automatic finish_chk(input string tag, input bit is_rd, input logic [15:0] erd);
      check({tag, " R7 done"}, 32'(done), 32'd1);
      if (is_rd) check({tag, " rdata"}, 32'(rdata), 32'(erd));
      @(negedge clk);
      check({tag, " R7 done low"}, 32'(done), 32'd0);
      check({tag, " idle"}, 32'(bus_cyc), 32'd0);
   endtask

   task automatic t_reset;
      check("R1 cyc", 32'(bus_cyc), 32'd0);
      check("R1 done", 32'(done), 32'd0);
      check("R1 be", 32'(bus_be), 32'd0);
   endtask

   task automatic t_bytes;
      issue(1, 0, 20'h12344, 16'h77A5);
      beat("R2 byte wr even", 20'h12344, 2'b01, 1, 16'h00A5, 0, 16'h0);
      finish_chk("R2 byte wr even", 0, 16'h0);
      issue(1, 0, 20'h12345, 16'h003C);
      beat("R3 byte wr odd", 20'h12345, 2'b10, 1, 16'h3C00, 2, 16'h0);
      finish_chk("R3 byte wr odd", 0, 16'h0);
      issue(0, 0, 20'h00010, 16'h0);
      beat("R2 byte rd even", 20'h00010, 2'b01, 0, 16'h0, 1, 16'hBEEF);
      finish_chk("R10 byte rd even", 1, 16'h00EF);
      issue(0, 0, 20'h00011, 16'h0);
      beat("R3 byte rd odd", 20'h00011, 2'b10, 0, 16'h0, 0, 16'hBEEF);
      finish_chk("R10 byte rd odd", 1, 16'h00BE);
   endtask

   task automatic t_even_word;
      issue(1, 1, 20'h00100, 16'h1234);
      beat("R4 word wr even", 20'h00100, 2'b11, 1, 16'h1234, 1, 16'h0);
      finish_chk("R4 word wr even", 0, 16'h0);
      issue(0, 1, 20'h00102, 16'h0);
      beat("R4 word rd even", 20'h00102, 2'b11, 0, 16'h0, 0, 16'hCAFE);
      finish_chk("R4 word rd even", 1, 16'hCAFE);
   endtask

   task automatic t_odd_word;
      issue(1, 1, 20'h00201, 16'hABCD);
      beat("R5 odd wr first", 20'h00201, 2'b10, 1, 16'hCD00, 1, 16'h0);
      check("R7 no done mid split", 32'(done), 32'd0);
      beat("R5 odd wr second", 20'h00202, 2'b01, 1, 16'h00AB, 1, 16'h0);
      finish_chk("R5 odd wr", 0, 16'h0);
      issue(0, 1, 20'h00301, 16'h0);
      beat("R5 odd rd first", 20'h00301, 2'b10, 0, 16'h0, 0, 16'h7711);
      check("R7 no done mid split rd", 32'(done), 32'd0);
      beat("R5 odd rd second", 20'h00302, 2'b01, 0, 16'h0, 2, 16'h2299);
      finish_chk("R7 odd rd merge", 1, 16'h9977);
   endtask

   task automatic t_wrap;
      issue(1, 1, 20'hFFFFF, 16'h5A6B);
      beat("R8 wrap first", 20'hFFFFF, 2'b10, 1, 16'h6B00, 0, 16'h0);
      beat("R8 wrap second", 20'h00000, 2'b01, 1, 16'h005A, 0, 16'h0);
      finish_chk("R8 wrap wr", 0, 16'h0);
      issue(0, 1, 20'hFFFFF, 16'h0);
      beat("R8 wrap rd first", 20'hFFFFF, 2'b10, 0, 16'h0, 0, 16'h4400);
      beat("R8 wrap rd second", 20'h00000, 2'b01, 0, 16'h0, 0, 16'h0033);
      finish_chk("R8 wrap rd", 1, 16'h3344);
   endtask

   task automatic t_busy;
      issue(0, 1, 20'h00400, 16'h0);
      req_valid = 1'b1; req_write = 1'b1; req_word = 1'b0;
      req_addr = 20'h0A0A1; req_wdata = 16'hFFFF;
      check("R9 addr at stray req", 32'(bus_addr), 32'h00400);
      @(negedge clk);
      req_valid = 1'b0;
      beat("R9 busy", 20'h00400, 2'b11, 0, 16'h0, 0, 16'h1357);
      finish_chk("R9 busy", 1, 16'h1357);
      check("R9 no extra cycle", 32'(bus_cyc), 32'd0);
   endtask

   initial begin
      #500us;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bytes();
      t_even_word();
      t_odd_word();
      t_wrap();
      t_busy();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule